// File: doc/BRIEF.md
# AC-link transmit slot formatter

This block drives the outbound half of an AC'97-style serial link. It runs on the codec's bit clock. It builds 256-bit frames, each made of a 16-bit tag slot and twelve 20-bit data slots. It drives the frame marker on `sync_o` and the serial data on `sdata_o`. Two logical sample channels, A and B, each have a holding register that software fills over a simple write-only register bus. Each sample is formatted when it is written: the channel's byte order is applied, the configured width is taken, and the result is left-aligned into a 20-bit slot word. The word then waits in the holding register until a one-entry shift stage is free.

A slot assignment register maps each data slot to channel A, channel B or nothing. At the start of every frame the block decides which assigned slots it can fill from the samples already queued. It marks those slots in the tag and consumes one sample per marked slot, taking the slots in ascending order. A per-channel ready flag and interrupt tell software when the holding register can take the next sample.

Top module: `aclink_tx_fmt`

## Requirements
- R1: While control bit 0 (address 0) is clear, `sync_o` and `sdata_o` stay low and no frame is sent. Once it is set, frames follow each other with no gap, one every 256 bit clocks.
- R2: `sync_o` is high for exactly the first 16 bit clocks of each frame. Both outputs change only on the rising edge of `bit_clk_i`. Frame bit 0 appears after the second rising edge that follows the write enabling the link.
- R3: Tag layout: bit 15 is set when at least one data slot in the frame is valid. Bit 14-k flags data slot k (k = 0..11). Bits 2:0 are zero. Data slot k occupies frame bits 16+20k through 35+20k.
- R4: A slot is valid only when its assigned channel is enabled and a queued sample is available for it. An invalid slot carries all zeros. A disabled channel keeps its queued samples for later frames.
- R5: Width is set by channel configuration bits 2:1: 0 = 10 bits, 1 = 16 bits, 2 = 18 bits, 3 = 20 bits. The sample is taken from the low bits of the (possibly swapped) word and left-aligned in the slot with zero fill below. Higher written bits are ignored.
- R6: When channel configuration bit 3 is set, the four bytes of the written 32-bit word are reversed before the sample is taken. When the bit is clear, the word is used as written.
- R7: Each slot word is shifted out most significant bit first. The tag is sent from bit 15 down.
- R8: Address 3 holds 2 bits per data slot, with slot k at bits 2k+1:2k: 1 = channel A, 2 = channel B, 0 or 3 = unassigned. Channel configuration bit 0 is the channel enable.
- R9: Slots assigned to the same channel draw successive samples in ascending slot order. A frame marks valid at most as many of a channel's slots as it had samples queued at frame start (holding plus shift stage, at most 2).
- R10: A channel's ready flag (`rdy_o[0]` = A, `rdy_o[1]` = B) is 1 after reset. It clears on a write to that channel's holding register (address 4 = A, 5 = B). It sets again when the holding content moves into the empty shift stage. A write while the holding register is full replaces the held sample.
- R11: `irq_o[c]` is high exactly while channel c is ready and enabled. It drops on the write to that channel's holding register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk_i | input | 1 | Link bit clock from the codec |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| sync_o | output | 1 | Frame marker, high during the tag slot |
| sdata_o | output | 1 | Serial frame data, MSB first |
| rdy_o | output | 2 | Per-channel ready flags, bit 0 = A, bit 1 = B |
| irq_o | output | 2 | Per-channel interrupt requests |

## Verification
The bench builds the block with its default twelve data slots and a 3-bit address, so each frame is exactly 256 bits long. This lets a monitor capture whole frames and compare the tag and every slot against the queued expectations. With twelve slots, one channel can be spread over three slots while it holds only two samples. That reaches the ascending-order rule and the limit of two samples per frame. Slot 11, the highest, exercises the tag bit 3 position and the last slot of the frame. With both channels present, a disabled channel can hold data, be enabled later, and then show that its retained and overwritten samples reach the link.

// File: rtl/aclink_pkg.sv
package aclink_pkg;
  localparam int SLOT_W = 20;
  localparam int TAG_W  = 16;
  localparam int NCH    = 2;

  localparam logic [2:0] ADDR_CTRL   = 3'd0;
  localparam logic [2:0] ADDR_CFG_A  = 3'd1;
  localparam logic [2:0] ADDR_CFG_B  = 3'd2;
  localparam logic [2:0] ADDR_ASG    = 3'd3;
  localparam logic [2:0] ADDR_HOLD_A = 3'd4;
  localparam logic [2:0] ADDR_HOLD_B = 3'd5;

  typedef enum logic [1:0] {W10 = 2'd0, W16 = 2'd1, W18 = 2'd2, W20 = 2'd3} width_e;

  typedef struct packed {
    logic   big_end;
    width_e wsel;
    logic   en;
  } chan_cfg_t;

  function automatic logic [SLOT_W-1:0] fmt_sample(input logic [31:0] d, input chan_cfg_t c);
    logic [31:0] x;
    x = c.big_end ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    unique case (c.wsel)
      W10:     return {x[9:0], 10'b0};
      W16:     return {x[15:0], 4'b0};
      W18:     return {x[17:0], 2'b0};
      default: return x[19:0];
    endcase
  endfunction
endpackage

// File: rtl/aclink_chan.sv
module aclink_chan
  import aclink_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [SLOT_W-1:0] wdata_i,
  input  logic              take_i,
  output logic [1:0]        avail_o,
  output logic [SLOT_W-1:0] stage_o,
  output logic              rdy_o
);
  logic              hold_full_q, stage_full_q;
  logic [SLOT_W-1:0] hold_q, stage_q;
  logic              move;

  assign move = hold_full_q && !stage_full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_full_q  <= 1'b0;
      stage_full_q <= 1'b0;
      hold_q       <= '0;
      stage_q      <= '0;
    end else begin
      if (wr_i) begin
        hold_q      <= wdata_i;
        hold_full_q <= 1'b1;
      end else if (move) begin
        hold_full_q <= 1'b0;
      end
      if (move) begin
        stage_q      <= hold_q;
        stage_full_q <= 1'b1;
      end else if (take_i) begin
        stage_full_q <= 1'b0;
      end
    end
  end

  assign avail_o = {1'b0, hold_full_q} + {1'b0, stage_full_q};
  assign stage_o = stage_q;
  assign rdy_o   = !hold_full_q;
endmodule

// File: rtl/aclink_frame.sv
module aclink_frame
  import aclink_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int POS_W = $clog2(SLOT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic             frame_start_o,
  output logic             seg_start_o,
  output logic             is_tag_o,
  output logic [IDX_W-1:0] slot_o
);
  logic [POS_W-1:0] pos_q;
  logic             tag_q;
  logic [IDX_W-1:0] slot_q;
  logic             seg_end;

  assign seg_end = tag_q ? (pos_q == POS_W'(TAG_W - 1)) : (pos_q == POS_W'(SLOT_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      tag_q  <= 1'b1;
      slot_q <= '0;
    end else if (!en_i) begin
      pos_q  <= '0;
      tag_q  <= 1'b1;
      slot_q <= '0;
    end else if (seg_end) begin
      pos_q <= '0;
      if (tag_q) begin
        tag_q  <= 1'b0;
        slot_q <= '0;
      end else if (slot_q == IDX_W'(NUM_SLOTS - 1)) begin
        tag_q  <= 1'b1;
        slot_q <= '0;
      end else begin
        slot_q <= slot_q + IDX_W'(1);
      end
    end else begin
      pos_q <= pos_q + POS_W'(1);
    end
  end

  assign seg_start_o   = en_i && (pos_q == '0);
  assign frame_start_o = seg_start_o && tag_q;
  assign is_tag_o      = tag_q;
  assign slot_o        = slot_q;
endmodule

// File: rtl/aclink_slot_sel.sv
module aclink_slot_sel
  import aclink_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic [2*NUM_SLOTS-1:0] asg_i,
  input  logic [NCH-1:0]         en_i,
  input  logic [1:0]             avail_i [NCH],
  output logic [NUM_SLOTS-1:0]   valid_o
);
  logic [CNT_W-1:0] used [NCH];

  // ascending scan: each slot claims the channel's next unclaimed sample
  always_comb begin
    valid_o = '0;
    for (int c = 0; c < NCH; c++) used[c] = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      for (int c = 0; c < NCH; c++) begin
        if (asg_i[2*k +: 2] == 2'(c + 1) && en_i[c] && used[c] < CNT_W'(avail_i[c])) begin
          valid_o[k] = 1'b1;
          used[c]    = used[c] + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/aclink_tx_fmt.sv
module aclink_tx_fmt
  import aclink_pkg::*;
#(
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 3,
  localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic              bit_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  output logic              sync_o,
  output logic              sdata_o,
  output logic [NCH-1:0]    rdy_o,
  output logic [NCH-1:0]    irq_o
);
  logic                   glb_en_q;
  chan_cfg_t              cfg_q [NCH];
  logic [2*NUM_SLOTS-1:0] asg_q;
  logic [NUM_SLOTS-1:0]   valid_c, valid_q;
  logic [1:0]             avail [NCH];
  logic [SLOT_W-1:0]      stage [NCH];
  logic [NCH-1:0]         take, ch_en;
  logic                   frame_start, seg_start, is_tag;
  logic [IDX_W-1:0]       slot;
  logic [1:0]             slot_ch;
  logic [TAG_W-1:0]       tag_c;
  logic [SLOT_W-1:0]      wd_c, sr_q;

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q <= 1'b0;
      asg_q    <= '0;
      for (int c = 0; c < NCH; c++) cfg_q[c] <= '0;
    end else if (wr_en_i) begin
      unique case (wr_addr_i)
        ADDR_W'(ADDR_CTRL):  glb_en_q <= wr_data_i[0];
        ADDR_W'(ADDR_CFG_A): cfg_q[0] <= chan_cfg_t'(wr_data_i[3:0]);
        ADDR_W'(ADDR_CFG_B): cfg_q[1] <= chan_cfg_t'(wr_data_i[3:0]);
        ADDR_W'(ADDR_ASG):   asg_q    <= wr_data_i[2*NUM_SLOTS-1:0];
        default: ;
      endcase
    end
  end

  aclink_frame #(.NUM_SLOTS(NUM_SLOTS)) u_frame (
    .clk_i(bit_clk_i), .rst_ni(rst_ni), .en_i(glb_en_q),
    .frame_start_o(frame_start), .seg_start_o(seg_start),
    .is_tag_o(is_tag), .slot_o(slot)
  );

  assign slot_ch = asg_q[2*int'(slot) +: 2];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic wr_hold;
    assign wr_hold  = wr_en_i && (wr_addr_i == ADDR_W'(ADDR_HOLD_A) + ADDR_W'(c));
    assign ch_en[c] = cfg_q[c].en;
    assign take[c]  = seg_start && !is_tag && valid_q[slot] && (slot_ch == 2'(c + 1));
    assign irq_o[c] = rdy_o[c] && ch_en[c];

    aclink_chan u_chan (
      .clk_i(bit_clk_i), .rst_ni(rst_ni), .wr_i(wr_hold),
      .wdata_i(fmt_sample(wr_data_i, cfg_q[c])), .take_i(take[c]),
      .avail_o(avail[c]), .stage_o(stage[c]), .rdy_o(rdy_o[c])
    );
  end

  aclink_slot_sel #(.NUM_SLOTS(NUM_SLOTS)) u_sel (
    .asg_i(asg_q), .en_i(ch_en), .avail_i(avail), .valid_o(valid_c)
  );

  always_comb begin
    tag_c            = '0;
    tag_c[TAG_W-1]   = |valid_c;
    for (int k = 0; k < NUM_SLOTS; k++) tag_c[TAG_W-2-k] = valid_c[k];
  end

  always_comb begin
    wd_c = '0;
    if (is_tag) wd_c = {tag_c, {(SLOT_W - TAG_W){1'b0}}};
    else if (take[0]) wd_c = stage[0];
    else if (take[1]) wd_c = stage[1];
  end

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      sync_o  <= 1'b0;
      sdata_o <= 1'b0;
      sr_q    <= '0;
    end else if (!glb_en_q) begin
      sync_o  <= 1'b0;
      sdata_o <= 1'b0;
      sr_q    <= '0;
    end else begin
      if (frame_start) valid_q <= valid_c;
      sync_o <= is_tag;
      if (seg_start) begin
        sdata_o <= wd_c[SLOT_W-1];
        sr_q    <= wd_c << 1;
      end else begin
        sdata_o <= sr_q[SLOT_W-1];
        sr_q    <= sr_q << 1;
      end
    end
  end
endmodule

// File: rtl/aclink_tx_chk.sv
module aclink_tx_chk
  import aclink_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input logic              bit_clk_i,
  input logic              rst_ni,
  input logic              glb_en_q,
  input logic              sync_o,
  input logic              sdata_o,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [NCH-1:0]    rdy_o,
  input logic [NCH-1:0]    irq_o
);
  logic [7:0] hi_len;
  logic       wr_a, wr_b;

  assign wr_a = wr_en_i && wr_addr_i == ADDR_W'(ADDR_HOLD_A);
  assign wr_b = wr_en_i && wr_addr_i == ADDR_W'(ADDR_HOLD_B);

  always_ff @(posedge bit_clk_i or negedge rst_ni) begin
    if (!rst_ni) hi_len <= '0;
    else if (sync_o) hi_len <= hi_len + 8'd1;
    else hi_len <= '0;
  end

  // R1
  idle_when_off_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    !glb_en_q |=> (!sync_o && !sdata_o));
  // R2
  sync_len_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    ($fell(sync_o) && glb_en_q) |-> hi_len == 8'(TAG_W));
  // R10
  wr_a_clr_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    wr_a |=> !rdy_o[0]);
  // R10
  wr_b_clr_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    wr_b |=> !rdy_o[1]);
  // R10
  rdy_a_hold_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    (rdy_o[0] && !wr_a) |=> rdy_o[0]);
  // R11
  irq_a_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    irq_o[0] |-> rdy_o[0]);
  // R11
  irq_b_chk: assert property (@(posedge bit_clk_i) disable iff (!rst_ni)
    irq_o[1] |-> rdy_o[1]);
endmodule

bind aclink_tx_fmt aclink_tx_chk #(.ADDR_W(ADDR_W)) u_chk (
  .bit_clk_i(bit_clk_i), .rst_ni(rst_ni), .glb_en_q(glb_en_q),
  .sync_o(sync_o), .sdata_o(sdata_o), .wr_en_i(wr_en_i),
  .wr_addr_i(wr_addr_i), .rdy_o(rdy_o), .irq_o(irq_o)
);

// File: tb/sim_aclink_tx_fmt.sv
module sim_aclink_tx_fmt;
  typedef struct packed {
    logic [15:0]  tag;
    logic [239:0] sl;
  } frame_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        sync, sdata;
  logic [1:0]  rdy, irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_busy = 0;
  frame_t q[$];
  frame_t cur;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aclink_tx_fmt u0 (
    .bit_clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .sync_o(sync), .sdata_o(sdata), .rdy_o(rdy), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic exp_clear();
    cur = '0;
  endtask

  task automatic exp_slot(input int k, input logic [19:0] v);
    cur.sl[239-20*k -: 20] = v;
    cur.tag[15] = 1'b1;
    cur.tag[14-k] = 1'b1;
  endtask

  task automatic run_frames();
    wr(3'd0, 32'd1);
    while (q.size() != 0 || mon_busy) @(negedge clk);
    wr(3'd0, 32'd0);
    repeat (300) @(negedge clk);
  endtask

  // monitor: capture whole frames and compare with the queue head
  initial begin
    logic prev_s;
    int last_start;
    prev_s = 1'b0;
    last_start = -1000;
    forever begin
      @(negedge clk);
      if (sync && !prev_s && q.size() > 0) begin
        frame_t e;
        logic [255:0] fr, sy;
        mon_busy = 1;
        e = q.pop_front();
        if (cyc - last_start < 300) chk("R1 frame period", 32'(cyc - last_start), 32'd256);
        last_start = cyc;
        fr = {255'b0, sdata};
        sy = {255'b0, sync};
        repeat (255) begin
          @(negedge clk);
          fr = {fr[254:0], sdata};
          sy = {sy[254:0], sync};
        end
        chk("R2 sync high bits", 32'($countones(sy)), 32'd16);
        chk("R2 sync position", 32'(sy[255:240]), 32'hFFFF);
        chk("R3 tag", 32'(fr[255:240]), 32'(e.tag));
        for (int k = 0; k < 12; k++)
          chk($sformatf("R4 R7 slot %0d", k), 32'(fr[239-20*k -: 20]), 32'(e.sl[239-20*k -: 20]));
        prev_s = 1'b0;
        mon_busy = 0;
      end else begin
        prev_s = sync;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk("R1 reset sync", 32'(sync), 0);
    chk("R1 reset sdata", 32'(sdata), 0);
    chk("R10 reset rdy", 32'(rdy), 32'h3);
    chk("R11 reset irq", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // phase 1: A 16-bit little-endian, B 20-bit big-endian
    wr(3'd1, 32'h3);
    wr(3'd2, 32'hF);
    wr(3'd3, 32'h90);                 // R8 slot2 -> A, slot3 -> B
    wr(3'd4, 32'hFFFF1234);
    chk("R10 rdy cleared by write", 32'(rdy[0]), 0);
    @(negedge clk);
    chk("R10 rdy set on move", 32'(rdy[0]), 1);
    chk("R11 irq on ready", 32'(irq[0]), 1);
    wr(3'd4, 32'h0000ABCD);
    repeat (3) @(negedge clk);
    chk("R10 rdy held while stage full", 32'(rdy[0]), 0);
    chk("R11 irq dropped by write", 32'(irq[0]), 0);
    wr(3'd5, 32'h12345678);
    @(negedge clk);
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (sync || sdata) seen = 1;
    end
    chk("R1 idle while disabled", 32'(seen), 0);
    exp_clear(); exp_slot(2, 20'h12340); exp_slot(3, 20'h63412); q.push_back(cur);  // R5 R6
    exp_clear(); exp_slot(2, 20'hABCD0); q.push_back(cur);
    exp_clear(); q.push_back(cur);
    run_frames();
    chk("R10 both ready after drain", 32'(rdy), 32'h3);

    // phase 2: A 10-bit over three slots, B disabled 18-bit big-endian
    wr(3'd1, 32'h1);
    wr(3'd2, 32'hC);
    wr(3'd3, 32'h840401);             // R8 slots 0,5,9 -> A, slot 11 -> B
    wr(3'd4, 32'h000003FF);
    wr(3'd4, 32'hFFFFF155);
    wr(3'd5, 32'h0302FFAB);
    @(negedge clk);
    chk("R10 rdy B after move", 32'(rdy[1]), 1);
    chk("R11 irq masked when disabled", 32'(irq[1]), 0);
    wr(3'd5, 32'h11111111);
    wr(3'd5, 32'h5A000000);
    chk("R10 rdy B full", 32'(rdy[1]), 0);
    exp_clear(); exp_slot(0, 20'hFFC00); exp_slot(5, 20'h55400); q.push_back(cur);  // R9
    run_frames();

    // phase 3: enable B, retained and overwritten samples appear
    wr(3'd2, 32'hD);
    chk("R11 irq B not ready", 32'(irq[1]), 0);
    exp_clear(); exp_slot(11, 20'hC080C); q.push_back(cur);  // R4 R6
    exp_clear(); exp_slot(11, 20'h00168); q.push_back(cur);  // R10 overwrite
    run_frames();
    chk("R10 rdy B after drain", 32'(rdy[1]), 1);
    chk("R11 irq B ready and enabled", 32'(irq[1]), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule